// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets a clocked host talk to an external asynchronous static RAM of 131,072 sixteen-bit words. The RAM has active-low chip, output and write strobes, plus one active-low enable per byte lane. The host presents an address, write data, a two-bit lane mask and a read or write flag. It holds its request until the controller returns a one-cycle ready pulse, and read data is valid in that same cycle. The controller never has more than one transaction open.

The memory's nanosecond limits become wait-state counts at elaboration: each one is the limit divided by the clock-period parameter, rounded up. A read holds chip, output and lane enables low for the access window and registers the bus on its last cycle. A write holds write enable low long enough for the pulse, enable-overlap and data-setup minimums. The write ends on the rising edge of write enable while the chip enable is still low, and only the masked lanes change. The data-bus driver is switched on only during writes. It is always off before output enable falls, and it stays off for the memory's turn-off time after a read.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is low, and after it, until the first request: chip, output and write enables and both lane enables are high, the bus driver enable is 0 and ready is 0.
- R2: A read holds chip enable and output enable low, and write enable high, for ceil(70/CLK_NS) cycles (7 at 10 ns). It then raises them and pulses ready, with the read data registered from the bus on the last low cycle.
- R3: Mask bit 0 selects the low lane (data bits 7:0, lane enable bit 0); mask bit 1 selects the high lane (bits 15:8, lane enable bit 1). On a read, a lane whose mask bit is 0 keeps its lane enable high and returns zero in the read data.
- R4: A write changes only the lanes whose mask bit is 1; the other lane of that word keeps its stored value.
- R5: During a write, write enable stays low for at least max(ceil(55/CLK_NS), ceil(60/CLK_NS), ceil(30/CLK_NS)) cycles (6 at 10 ns) with chip enable low and the driven data unchanged. Write enable rises while chip enable is still low, and the whole write spans at least ceil(70/CLK_NS) cycles.
- R6: The bus driver is never enabled while output enable is low, and it is already off in the cycle before output enable falls.
- R7: After output enable rises, the driver stays off for at least ceil(25/CLK_NS) cycles (3 at 10 ns). A write requested in the cycle after a read's ready therefore completes with a latency of 9 cycles instead of 8.
- R8: A write whose mask is zero returns ready on the next cycle and never asserts write enable; memory contents are unchanged.
- R9: A held request gives exactly one ready pulse of one cycle. A read or masked write requested while idle completes with ready visible 8 cycles after the request cycle (10 ns clock).
- R10: The memory address equals the full 17-bit host address captured when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request, held until ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane select, bit 0 low byte |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with ready |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Lane enables, active low, bit 0 low byte |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory pads |

## Verification
If the wait counter loads the wrong value, the memory model is sampled too early. The read data then carries the model's not-yet-valid pattern in the very read where the error occurs, and the ready latency moves by the same number of cycles. A stuck or early driver-enable state shows up as contention or a short turnaround within the first read that follows a write. A mask decoded into the wrong lane corrupts the other byte, which shows up on the next read of that word.

// File: rtl/sram_lane_pkg.sv
// Shared types and elaboration-time helpers for the SRAM lane controller.
// Assumes all timing limits are given as whole nanoseconds.
package sram_lane_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WPULSE = 2'd2,
        ST_WREC   = 2'd3
    } ctrl_state_t;

    // Number of whole clock cycles covering ns_val nanoseconds.
    function automatic int cycles_for(input int ns_val, input int clk_ns);
        return (ns_val + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Loadable down-counter that times the wait states of one memory phase.
// Assumes load values fit in CNT_W bits; done_o is high when the count is zero.
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_turn_guard.sv
// Holds off the bus driver after output enable is released.
// Assumes TURN_CYC >= 1; clear_o rises TURN_CYC cycles after release_i.
module sram_turn_guard #(
    parameter int TURN_CYC = 3,
    parameter int CNT_W    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic release_i,
    output logic clear_o
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(TURN_CYC - 1);
    logic [CNT_W-1:0] gap_q;

    // Restart the hold-off on each release, then count it out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (release_i)
            gap_q <= LOAD_V;
        else if (gap_q != '0)
            gap_q <= gap_q - 1'b1;
    end

    assign clear_o = (gap_q == '0) && !release_i;
endmodule

// File: rtl/sram_lane_capture.sv
// Registers read data per byte lane; unselected lanes are returned as zero.
// Assumes DATA_W = 8 * LANES.
module sram_lane_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [LANES-1:0]  lane_en_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture one byte lane when the read window closes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata_o[g*8 +: 8] <= '0;
            else if (cap_i)
                rdata_o[g*8 +: 8] <= lane_en_i[g] ? dq_i[g*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
// Host-to-asynchronous-SRAM controller with byte-lane masking.
// Converts nanosecond limits to wait states via CLK_NS; one transaction at a time.
// Assumes the host holds host_req and its fields stable until host_ready.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 16,
    parameter int T_ACC_NS  = 70,
    parameter int T_OE_NS   = 35,
    parameter int T_WC_NS   = 70,
    parameter int T_WP_NS   = 55,
    parameter int T_OVL_NS  = 60,
    parameter int T_DS_NS   = 30,
    parameter int T_OFF_NS  = 25,
    localparam int LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_mask,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC   = max2(cycles_for(T_ACC_NS, CLK_NS), cycles_for(T_OE_NS, CLK_NS));
    localparam int WP_CYC   = max2(max2(cycles_for(T_WP_NS, CLK_NS), cycles_for(T_OVL_NS, CLK_NS)),
                                   max2(cycles_for(T_DS_NS, CLK_NS), 1));
    localparam int WC_CYC   = cycles_for(T_WC_NS, CLK_NS);
    localparam int REC_CYC  = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int TURN_CYC = max2(cycles_for(T_OFF_NS, CLK_NS), 1);
    localparam int CNT_W    = $clog2(RD_CYC + WP_CYC + REC_CYC + TURN_CYC + 1) + 1;

    ctrl_state_t      state_q;
    logic             tmr_load, tmr_done, turn_clear;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, acc_rd, acc_wr, acc_zero, rd_end, wp_end, wr_end;

    assign accept   = (state_q == ST_IDLE) && host_req && !host_ready;
    assign acc_rd   = accept && !host_wr;
    assign acc_zero = accept && host_wr && (host_mask == '0);
    assign acc_wr   = accept && host_wr && (host_mask != '0) && turn_clear;
    assign rd_end   = (state_q == ST_READ)   && tmr_done;
    assign wp_end   = (state_q == ST_WPULSE) && tmr_done;
    assign wr_end   = (state_q == ST_WREC)   && tmr_done;

    // Pick the length of the phase that starts on this edge.
    always_comb begin
        tmr_load = 1'b1;
        tmr_val  = '0;
        if (acc_rd)
            tmr_val = CNT_W'(RD_CYC - 1);
        else if (acc_wr)
            tmr_val = CNT_W'(WP_CYC - 1);
        else if (wp_end)
            tmr_val = CNT_W'(REC_CYC - 1);
        else
            tmr_load = 1'b0;
    end

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    sram_turn_guard #(.TURN_CYC(TURN_CYC), .CNT_W(CNT_W)) u_turn (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_i (rd_end),
        .clear_o   (turn_clear)
    );

    sram_lane_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (rd_end),
        .lane_en_i (~mem_lane_n),
        .dq_i      (mem_dq_in),
        .rdata_o   (host_rdata)
    );

    // Sequence the memory strobes, the bus driver and the ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mem_addr   <= '0;
            mem_ce_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_lane_n <= '1;
            mem_dq_out <= '0;
            mem_dq_oe  <= 1'b0;
            host_ready <= 1'b0;
        end else begin
            host_ready <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_zero) begin
                        host_ready <= 1'b1;
                    end else if (acc_rd) begin
                        mem_addr   <= host_addr;
                        mem_ce_n   <= 1'b0;
                        mem_oe_n   <= 1'b0;
                        mem_lane_n <= ~host_mask;
                        state_q    <= ST_READ;
                    end else if (acc_wr) begin
                        mem_addr   <= host_addr;
                        mem_dq_out <= host_wdata;
                        mem_dq_oe  <= 1'b1;
                        mem_ce_n   <= 1'b0;
                        mem_we_n   <= 1'b0;
                        mem_lane_n <= ~host_mask;
                        state_q    <= ST_WPULSE;
                    end
                end
                ST_READ: begin
                    if (tmr_done) begin
                        mem_ce_n   <= 1'b1;
                        mem_oe_n   <= 1'b1;
                        mem_lane_n <= '1;
                        host_ready <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                ST_WPULSE: begin
                    if (tmr_done) begin
                        mem_we_n <= 1'b1;
                        state_q  <= ST_WREC;
                    end
                end
                ST_WREC: begin
                    if (wr_end) begin
                        mem_ce_n   <= 1'b1;
                        mem_lane_n <= '1;
                        mem_dq_oe  <= 1'b0;
                        host_ready <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sram_lane_chk.sv
// Protocol checker for sram_lane_ctrl, attached by bind below.
// Counters replace long $past windows so large clock ratios stay cheap.
module sram_lane_chk
    import sram_lane_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int T_WP_NS  = 55,
    parameter int T_OVL_NS = 60,
    parameter int T_DS_NS  = 30,
    parameter int T_OFF_NS = 25,
    parameter int DATA_W   = 16,
    parameter int LANES    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [LANES-1:0]  mem_lane_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input logic              host_ready
);
    localparam int WP_CYC   = max2(max2(cycles_for(T_WP_NS, CLK_NS), cycles_for(T_OVL_NS, CLK_NS)),
                                   max2(cycles_for(T_DS_NS, CLK_NS), 1));
    localparam int TURN_CYC = max2(cycles_for(T_OFF_NS, CLK_NS), 1);
    localparam int CW       = 8;
    localparam logic [CW-1:0] SAT = '1;

    logic [CW-1:0] we_low_q, oe_gap_q;

    // Count write-enable low cycles and cycles since output enable rose.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_q <= '0;
            oe_gap_q <= SAT;
        end else begin
            we_low_q <= mem_we_n ? '0 : ((we_low_q == SAT) ? SAT : we_low_q + 1'b1);
            oe_gap_q <= !mem_oe_n ? '0 : ((oe_gap_q == SAT) ? SAT : oe_gap_q + 1'b1);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_ready)); // R1
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R6
    AST_DRIVE_OFF_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R6
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_dq_oe) |-> (oe_gap_q >= CW'(TURN_CYC))); // R7
    AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (we_low_q >= CW'(WP_CYC))); // R5
    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (!mem_ce_n && mem_dq_oe)); // R5
    AST_WE_END_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> !mem_ce_n); // R5
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out)); // R5
    AST_WE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (mem_lane_n != '1)); // R8
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) host_ready |=> !host_ready); // R9
endmodule

bind sram_lane_ctrl sram_lane_chk #(
    .CLK_NS   (CLK_NS),
    .T_WP_NS  (T_WP_NS),
    .T_OVL_NS (T_OVL_NS),
    .T_DS_NS  (T_DS_NS),
    .T_OFF_NS (T_OFF_NS),
    .DATA_W   (DATA_W),
    .LANES    (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_lane_n (mem_lane_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .host_ready (host_ready)
);

// File: tb/tb_sram_lane_ctrl.sv
// Bench: behavioural SRAM model with timing monitors, a vector table, directed tests.
module tb_sram_lane_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [16:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_mask = '0;
    logic        host_ready;
    logic [15:0] host_rdata, mem_dq_out, mem_dq_in;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sram_lane_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
        .host_ready(host_ready), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- memory model (64 words keyed by addr[5:0]) ----------------
    logic [15:0] mem [64];
    logic [16:0] last_waddr = '0;
    int wr_events = 0, rd_age = 0, we_low = 0, oe_gap = 100;
    logic        we_prev = 1'b1;
    logic [15:0] wd_at_fall = '0;

    initial for (int i = 0; i < 64; i++) mem[i] = '0;

    // Read data is valid only after 7 full cycles of active read enables.
    always_comb begin
        logic [15:0] w;
        w = mem[mem_addr[5:0]];
        mem_dq_in = 16'hBAD0;
        if (rd_age >= 7) begin
            mem_dq_in[7:0]  = !mem_lane_n[0] ? w[7:0]  : 8'h5A;
            mem_dq_in[15:8] = !mem_lane_n[1] ? w[15:8] : 8'h5A;
        end
    end

    // Monitor the memory side at each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe) begin
                chk(mem_oe_n, "R6 drive while oe low", {31'd0, mem_oe_n}, 32'd1);
                if (oe_gap < 3)
                    chk(1'b0, "R7 turnaround gap", oe_gap, 32'd3);
            end
            if (!mem_we_n && we_prev) wd_at_fall = mem_dq_out;
            if (mem_we_n && !we_prev) begin
                chk(we_low >= 6, "R5 write pulse cycles", we_low, 32'd6);
                chk(!mem_ce_n, "R5 ce low at we rise", {31'd0, mem_ce_n}, 32'd0);
                chk(mem_dq_out == wd_at_fall, "R5 data stable", {16'd0, mem_dq_out}, {16'd0, wd_at_fall});
                if (!mem_lane_n[0]) mem[mem_addr[5:0]][7:0]  = mem_dq_out[7:0];
                if (!mem_lane_n[1]) mem[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
                last_waddr = mem_addr;
                wr_events++;
            end
        end
        we_low  = mem_we_n ? 0 : we_low + 1;
        oe_gap  = !mem_oe_n ? 0 : ((oe_gap < 100) ? oe_gap + 1 : 100);
        rd_age  = (!mem_ce_n && !mem_oe_n && mem_we_n) ? rd_age + 1 : 0;
        we_prev = mem_we_n;
    end

    // ---------------- host driver ----------------
    task automatic run_tx(input bit wr, input logic [1:0] m, input logic [16:0] a,
                          input logic [15:0] d, output logic [15:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_mask = m; host_addr = a; host_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ready && lat < 60);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    // {wr, mask, addr, wdata, expected read}
    localparam logic [51:0] VEC [11] = '{
        {1'b1, 2'b11, 17'h00001, 16'hA5C3, 16'h0000},
        {1'b1, 2'b11, 17'h1F002, 16'h1234, 16'h0000},
        {1'b0, 2'b11, 17'h00001, 16'h0000, 16'hA5C3},
        {1'b1, 2'b01, 17'h00001, 16'hFF77, 16'h0000},
        {1'b0, 2'b11, 17'h00001, 16'h0000, 16'hA577},
        {1'b1, 2'b10, 17'h1F002, 16'hBEEF, 16'h0000},
        {1'b0, 2'b11, 17'h1F002, 16'h0000, 16'hBE34},
        {1'b0, 2'b01, 17'h1F002, 16'h0000, 16'h0034},
        {1'b0, 2'b10, 17'h00001, 16'h0000, 16'hA500},
        {1'b1, 2'b00, 17'h00001, 16'h0000, 16'h0000},
        {1'b0, 2'b11, 17'h00001, 16'h0000, 16'hA577}
    };

    initial begin
        logic [15:0] rd;
        int lat, exp_lat, ev_before;
        bit prev_rd = 1'b0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
            {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd7);
        chk(mem_lane_n == 2'b11, "R1 lanes high in reset", {30'd0, mem_lane_n}, 32'd3);
        chk(!mem_dq_oe && !host_ready, "R1 driver off, ready low", {30'd0, mem_dq_oe, host_ready}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle after reset",
            {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 32'hE);

        foreach (VEC[i]) begin
            logic [51:0] v;
            v = VEC[i];
            ev_before = wr_events;
            exp_lat = (v[51] && v[50:49] == 2'b00) ? 1 : ((v[51] && prev_rd) ? 9 : 8);
            run_tx(v[51], v[50:49], v[48:32], v[31:16], rd, lat);
            if (!v[51]) begin
                chk(rd == v[15:0], "R2 R3 read data", {16'd0, rd}, {16'd0, v[15:0]});
                chk(lat == exp_lat, "R2 R9 read latency", lat, exp_lat);
            end else if (v[50:49] == 2'b00) begin
                chk(lat == 1, "R8 zero-mask latency", lat, 32'd1);
                chk(wr_events == ev_before, "R8 no write strobe", wr_events, ev_before);
            end else begin
                chk(lat == exp_lat, prev_rd ? "R7 write after read latency" : "R9 write latency", lat, exp_lat);
                chk(last_waddr == v[48:32], "R10 full address", {15'd0, last_waddr}, {15'd0, v[48:32]});
                chk(wr_events == ev_before + 1, "R4 one write strobe", wr_events, ev_before + 1);
            end
            prev_rd = !v[51];
        end

        // R9: ready is a single-cycle pulse
        @(negedge clk);
        chk(!host_ready, "R9 ready single pulse", {31'd0, host_ready}, 32'd0);
        // R4: untouched upper bits of a high-address word survive a low-lane write
        run_tx(1'b1, 2'b01, 17'h1F002, 16'h00AA, rd, lat);
        run_tx(1'b0, 2'b11, 17'h1F002, 16'h0000, rd, lat);
        chk(rd == 16'hBEAA, "R4 lane isolation", {16'd0, rd}, 32'h0000BEAA);
        // R3: a read with mask zero returns zero
        run_tx(1'b0, 2'b00, 17'h00001, 16'h0000, rd, lat);
        chk(rd == 16'h0000, "R3 no lanes read", {16'd0, rd}, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R9 watchdog expired", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule